// File: doc/BRIEF.md
# Dual-I/O Continuous-Read Command Decoder

This block is the receiving front end of a serial flash device. It watches chip select, serial clock and two data lines. It recovers the command opcode and, for the dual-line fast read, the 24-bit address and a trailing mode byte. It then raises a one-cycle read request for the array logic behind it.

The mode byte decides whether the block enters a continuous-read state. In that state, the next select cycle carries no opcode and starts directly with the address. This cuts the cost of each random access when code runs straight from the flash. The block leaves the state in two ways: a mode byte that does not request it, or a frame whose first sixteen clocks all hold the primary data line high. The block has no reset pin of its own. For that reason, the all-ones frame is the way a host that has just restarted brings the device back to normal command decoding.

The serial lines are sampled by a faster system clock `clk`. A serial clock edge counts once the system clock has seen the line go from low to high while chip select is low. Each captured edge appears on the outputs one `clk` cycle later. The `por_n` input only models power-on initialisation. Data output timing and the memory array are handled elsewhere.

Top module: `dxr_xip_decoder`

## Requirements
- R1: After `por_n` is released, `xip_active`, `rd_req` and `cmd_valid` are 0, and `cmd_code` and `rd_addr` are all zeros.
- R2: Outside continuous mode, the first 8 rising serial edges of a select cycle shift an opcode in from `io0`, most significant bit first. One `clk` cycle after the 8th edge, `cmd_code` holds that opcode and `cmd_valid` is high for exactly one cycle.
- R3: After opcode 0xBB, the next 12 rising edges carry the address two bits per edge, most significant pair first, with `io1` as the higher bit of each pair. The 4 edges after that carry the mode byte in the same way. One cycle after the 4th mode edge, `rd_req` pulses for one cycle and `rd_addr` shows the address.
- R4: An opcode other than 0xBB produces no `rd_req` and does not change `xip_active` for the rest of that select cycle.
- R5: When the mode byte completes, `xip_active` becomes 1 exactly when mode bits [5:4] equal 2'b10. Bits [7:6] and [3:0] have no effect.
- R6: While `xip_active` is 1, a select cycle has no opcode phase. On its first rising edge `cmd_code` becomes 0xBB and `cmd_valid` pulses. Then 12 address edges and 4 mode edges follow as in R3.
- R7: If `io0` is 1 on each of the first 16 rising edges of a select cycle, `xip_active` is 0 after the 16th edge and that select cycle issues no `rd_req`, in either mode.
- R8: Raising `cs_n` abandons a partial frame, and the next select cycle starts from its first edge. Raising `cs_n` never changes `xip_active`.
- R9: Decoding is the same whether `sclk` idles low or high between select cycles. Only low-to-high transitions that occur while `cs_n` is low are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| por_n | input | 1 | Model-level power-on initialisation, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| io0 | input | 1 | Data line 0: single-line input and even bits in dual transfers |
| io1 | input | 1 | Data line 1: odd bits in dual transfers |
| cmd_code | output | 8 | Most recent decoded or implied opcode |
| cmd_valid | output | 1 | One-cycle pulse when `cmd_code` is updated |
| rd_addr | output | ADDR_W | Address of the most recent dual read |
| rd_req | output | 1 | One-cycle pulse when a dual read's address and mode byte are complete |
| xip_active | output | 1 | Continuous-read state: next select cycle omits the opcode |

## Verification
The bench sends several kinds of frame:
- Full dual reads with mode bytes that do or do not request continuous mode, with the ignored mode bits set to varied values. These separate a correct bit [5:4] decode from one that looks at other bits.
- The same reads with `sclk` idling high and idling low, which exposes any dependence on the idle level.
- Continuous frames that are cut short by chip select. These show that a partial frame neither issues a request nor disturbs the state.
- All-ones frames sent in both states, and frames with ordinary opcodes. These tell the break sequence apart from a normal dual read and from unrelated commands.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_ADDR = 3'd2,
    PH_MODE = 3'd3,
    PH_DATA = 3'd4,
    PH_SKIP = 3'd5
  } phase_t;

  localparam logic [7:0] DUAL_READ_OPC = 8'hBB;

  // Mode byte request for staying in continuous read: bits [5:4] == 2'b10.
  function automatic logic mode_keeps_xip(input logic [7:0] mb);
    return (mb[5:4] == 2'b10);
  endfunction

  // Phase that follows a completed phase.
  function automatic phase_t phase_after(input phase_t ph, input logic is_read);
    phase_t nx;
    case (ph)
      PH_OPC:  nx = is_read ? PH_ADDR : PH_SKIP;
      PH_ADDR: nx = PH_MODE;
      PH_MODE: nx = PH_DATA;
      default: nx = ph;
    endcase
    return nx;
  endfunction

  // Pair of bits taken on one dual edge; io1 is the higher bit.
  function automatic logic [1:0] dual_pair(input logic hi, input logic lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/dxr_sclk_edge.sv
module dxr_sclk_edge (
  input  logic clk,
  input  logic por_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise
);

  logic sclk_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = !cs_n && sclk && !sclk_q;

  // R9: one serial edge yields one sample event, never two in a row
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (!por_n)
    rise |=> !rise);

endmodule

// File: rtl/dxr_frame_seq.sv
module dxr_frame_seq
  import dxr_pkg::*;
#(
  parameter int OPC_CLKS  = 8,
  parameter int ADDR_CLKS = 12,
  parameter int MODE_CLKS = 4
) (
  input  logic   clk,
  input  logic   por_n,
  input  logic   cs_n,
  input  logic   rise,
  input  logic   xip,
  input  logic   opc_is_read,
  output phase_t slot,
  output logic   ev_opc_done,
  output logic   ev_mode_done,
  output logic   ev_implicit
);

  localparam int LONGEST = (OPC_CLKS > ADDR_CLKS) ?
                           ((OPC_CLKS > MODE_CLKS) ? OPC_CLKS : MODE_CLKS) :
                           ((ADDR_CLKS > MODE_CLKS) ? ADDR_CLKS : MODE_CLKS);
  localparam int CNT_W = $clog2(LONGEST + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_eff;
  logic             last;
  logic             open_ended;

  always_comb begin
    slot    = phase;
    cnt_eff = cnt;
    if (phase == PH_IDLE) begin
      slot    = xip ? PH_ADDR : PH_OPC;
      cnt_eff = '0;
    end
  end

  always_comb begin
    case (slot)
      PH_OPC:  last = (cnt_eff == CNT_W'(OPC_CLKS - 1));
      PH_ADDR: last = (cnt_eff == CNT_W'(ADDR_CLKS - 1));
      PH_MODE: last = (cnt_eff == CNT_W'(MODE_CLKS - 1));
      default: last = 1'b0;
    endcase
  end

  assign open_ended = (slot == PH_DATA) || (slot == PH_SKIP);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (cs_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (rise) begin
      if (last) begin
        phase <= phase_after(slot, opc_is_read);
        cnt   <= '0;
      end else if (open_ended) begin
        phase <= slot;
      end else begin
        phase <= slot;
        cnt   <= cnt_eff + CNT_W'(1);
      end
    end
  end

  assign ev_opc_done  = rise && (slot == PH_OPC)  && last;
  assign ev_mode_done = rise && (slot == PH_MODE) && last;
  assign ev_implicit  = rise && (phase == PH_IDLE) && xip;

  // R2/R3: frame events are mutually exclusive
  assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({ev_opc_done, ev_mode_done, ev_implicit}));

  // R2/R4: after the opcode the frame is either a dual read or ignored
  assert_opc_branch_R4: assert property (@(posedge clk) disable iff (!por_n)
    ev_opc_done |=> (phase == PH_ADDR || phase == PH_SKIP));

  // R6: a continuous frame goes straight to the address phase
  assert_no_opc_in_xip_R6: assert property (@(posedge clk) disable iff (!por_n)
    ev_implicit |=> (phase == PH_ADDR || cs_n));

  // R8: deselect returns the sequencer to the frame start
  assert_deselect_restart_R8: assert property (@(posedge clk) disable iff (!por_n)
    cs_n |=> (phase == PH_IDLE));

endmodule

// File: rtl/dxr_field_capture.sv
module dxr_field_capture
  import dxr_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 24,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rise,
  input  phase_t            slot,
  input  logic              io0,
  input  logic              io1,
  output logic [OPC_W-1:0]  opc_next,
  output logic [MODE_W-1:0] mode_next,
  output logic [ADDR_W-1:0] addr_hold
);

  logic [OPC_W-1:0]  opc_sr;
  logic [ADDR_W-1:0] addr_sr;
  logic [ADDR_W-1:0] addr_next;
  logic [MODE_W-1:0] mode_sr;

  assign opc_next  = {opc_sr[OPC_W-2:0], io0};
  assign addr_next = {addr_sr[ADDR_W-3:0], dual_pair(io1, io0)};
  assign mode_next = {mode_sr[MODE_W-3:0], dual_pair(io1, io0)};
  assign addr_hold = addr_sr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opc_sr  <= '0;
      addr_sr <= '0;
      mode_sr <= '0;
    end else if (rise) begin
      case (slot)
        PH_OPC:  opc_sr  <= opc_next;
        PH_ADDR: addr_sr <= addr_next;
        PH_MODE: mode_sr <= mode_next;
        default: ;
      endcase
    end
  end

  // R3: the address stays put while the mode byte is being received
  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!por_n)
    (rise && slot == PH_MODE) |=> $stable(addr_sr));

endmodule

// File: rtl/dxr_break_detect.sv
module dxr_break_detect #(
  parameter int BREAK_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic cs_n,
  input  logic rise,
  input  logic io0,
  output logic brk_fire
);

  localparam int RUN_W = $clog2(BREAK_LEN + 1);

  logic [RUN_W-1:0] ones_cnt;
  logic             ones_ok;
  logic             at_end;

  assign at_end   = (ones_cnt == RUN_W'(BREAK_LEN - 1));
  assign brk_fire = rise && ones_ok && io0 && at_end;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ones_cnt <= '0;
      ones_ok  <= 1'b1;
    end else if (cs_n) begin
      ones_cnt <= '0;
      ones_ok  <= 1'b1;
    end else if (rise && ones_ok) begin
      if (!io0 || at_end) ones_ok  <= 1'b0;
      else                ones_cnt <= ones_cnt + RUN_W'(1);
    end
  end

  // R7: the break fires at most once per select cycle
  assert_break_once_R7: assert property (@(posedge clk) disable iff (!por_n)
    brk_fire |=> !brk_fire);

endmodule

// File: rtl/dxr_xip_decoder.sv
module dxr_xip_decoder
  import dxr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BREAK_LEN = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              io0,
  input  logic              io1,
  output logic [7:0]        cmd_code,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  output logic              xip_active
);

  localparam int OPC_W     = $bits(DUAL_READ_OPC);
  localparam int MODE_W    = 8;
  localparam int ADDR_CLKS = ADDR_W / 2;
  localparam int MODE_CLKS = MODE_W / 2;

  logic              rise;
  phase_t            slot;
  logic              ev_opc_done;
  logic              ev_mode_done;
  logic              ev_implicit;
  logic              brk_fire;
  logic              opc_is_read;
  logic [OPC_W-1:0]  opc_next;
  logic [MODE_W-1:0] mode_next;
  logic [ADDR_W-1:0] addr_hold;
  logic              read_done;

  dxr_sclk_edge u_edge (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .sclk(sclk), .rise(rise)
  );

  dxr_frame_seq #(
    .OPC_CLKS(OPC_W), .ADDR_CLKS(ADDR_CLKS), .MODE_CLKS(MODE_CLKS)
  ) u_seq (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .rise(rise), .xip(xip_active),
    .opc_is_read(opc_is_read), .slot(slot), .ev_opc_done(ev_opc_done),
    .ev_mode_done(ev_mode_done), .ev_implicit(ev_implicit)
  );

  dxr_field_capture #(
    .OPC_W(OPC_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
  ) u_cap (
    .clk(clk), .por_n(por_n), .rise(rise), .slot(slot), .io0(io0), .io1(io1),
    .opc_next(opc_next), .mode_next(mode_next), .addr_hold(addr_hold)
  );

  dxr_break_detect #(.BREAK_LEN(BREAK_LEN)) u_brk (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .rise(rise), .io0(io0),
    .brk_fire(brk_fire)
  );

  assign opc_is_read = (opc_next == DUAL_READ_OPC);
  assign read_done   = ev_mode_done && !brk_fire;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      xip_active <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      cmd_code   <= '0;
      cmd_valid  <= 1'b0;
    end else begin
      rd_req    <= read_done;
      cmd_valid <= ev_opc_done || ev_implicit;
      if (brk_fire)       xip_active <= 1'b0;
      else if (read_done) xip_active <= mode_keeps_xip(mode_next);
      if (read_done)      rd_addr    <= addr_hold;
      if (ev_opc_done)    cmd_code   <= opc_next;
      else if (ev_implicit) cmd_code <= DUAL_READ_OPC;
    end
  end

  // R3: a read request is a single-cycle pulse
  assert_rdreq_pulse_R3: assert property (@(posedge clk) disable iff (!por_n)
    rd_req |=> !rd_req);

  // R7: the break sequence leaves continuous mode and issues no request
  assert_break_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    brk_fire |=> (!xip_active && !rd_req));

  // R8: chip select high never alters the continuous-mode state
  assert_xip_hold_deselect_R8: assert property (@(posedge clk) disable iff (!por_n)
    cs_n |=> $stable(xip_active));

  // R6: an opcode-less frame reports the implied dual read opcode
  assert_implicit_cmd_R6: assert property (@(posedge clk) disable iff (!por_n)
    ev_implicit |=> (cmd_valid && cmd_code == DUAL_READ_OPC));

endmodule

// File: tb/dxr_xip_decoder_test.sv
module dxr_xip_decoder_test;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        io0 = 1'b0;
  logic        io1 = 1'b0;
  logic [7:0]  cmd_code;
  logic        cmd_valid;
  logic [23:0] rd_addr;
  logic        rd_req;
  logic        xip_active;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rd_count = 0;
  logic [23:0] last_addr = '0;

  always #5 clk = ~clk;

  dxr_xip_decoder uut (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .sclk(sclk), .io0(io0), .io1(io1),
    .cmd_code(cmd_code), .cmd_valid(cmd_valid), .rd_addr(rd_addr),
    .rd_req(rd_req), .xip_active(xip_active)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  q[$];
  logic        m_sclk_q = 1'b0;
  logic        m_start_xip = 1'b0;
  logic        exp_xip = 1'b0, exp_rd = 1'b0, exp_cv = 1'b0;
  logic [7:0]  exp_cmd = '0;
  logic [23:0] exp_addr = '0;

  function automatic logic [7:0] opc_of();
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[6:0], q[i][0]};
    return v;
  endfunction

  function automatic bit first16_ones();
    for (int i = 0; i < 16; i++) if (q[i][0] !== 1'b1) return 0;
    return 1;
  endfunction

  task automatic finish_read(input int base);
    logic [23:0] a = '0;
    logic [7:0]  m = '0;
    for (int i = 0; i < 12; i++) a = {a[21:0], q[base + i]};
    for (int i = 0; i < 4; i++)  m = {m[5:0], q[base + 12 + i]};
    exp_addr = a;
    exp_rd   = 1'b1;
    exp_xip  = (m[5:4] == 2'b10);
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      q.delete();
      m_sclk_q = 1'b0; exp_xip = 0; exp_rd = 0; exp_cv = 0;
      exp_cmd = '0; exp_addr = '0;
    end else begin
      exp_rd = 0;
      exp_cv = 0;
      if (cs_n) q.delete();
      else if (sclk && !m_sclk_q) begin
        int n;
        bit brk;
        if (q.size() == 0) m_start_xip = exp_xip;
        q.push_back({io1, io0});
        n = q.size();
        brk = (n == 16) && first16_ones();
        if (m_start_xip) begin
          if (n == 1) begin exp_cv = 1; exp_cmd = 8'hBB; end
          if (n == 16 && !brk) finish_read(0);
        end else begin
          if (n == 8) begin exp_cv = 1; exp_cmd = opc_of(); end
          if (n == 24 && opc_of() == 8'hBB) finish_read(8);
        end
        if (brk) exp_xip = 0;
      end
      m_sclk_q = sclk;
    end
  end

  // per-clock comparison and read monitor
  always @(negedge clk) begin
    cyc++;
    if (por_n) begin
      chk(cmd_valid === exp_cv, "R2 cmd_valid", 32'(cmd_valid), 32'(exp_cv));
      chk(cmd_code === exp_cmd, "R2 cmd_code", 32'(cmd_code), 32'(exp_cmd));
      chk(rd_req === exp_rd, "R3 rd_req", 32'(rd_req), 32'(exp_rd));
      chk(rd_addr === exp_addr, "R3 rd_addr", 32'(rd_addr), 32'(exp_addr));
      chk(xip_active === exp_xip, "R5 xip_active", 32'(xip_active), 32'(exp_xip));
      if (rd_req) begin rd_count++; last_addr = rd_addr; end
    end
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [1:0] tx[$];

  task automatic push_opc(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) tx.push_back({1'b0, v[i]});
  endtask

  task automatic push_dual(input logic [23:0] v, input int bits);
    for (int i = bits - 2; i >= 0; i -= 2) tx.push_back(v[i +: 2]);
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) tx.push_back({i[0], 1'b1});
  endtask

  task automatic push_fill(input int n);
    for (int i = 0; i < n; i++) tx.push_back(i[1:0]);
  endtask

  task automatic run_frame(input bit mode3, input int limit);
    sclk = mode3;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < tx.size() && k < limit; k++) begin
      sclk = 1'b0;
      {io1, io0} = tx[k];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    if (!mode3) sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    tx.delete();
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(xip_active === 0, "R1 xip after reset", 32'(xip_active), 0);
    chk(rd_req === 0 && cmd_valid === 0, "R1 strobes after reset",
        32'({rd_req, cmd_valid}), 0);
    chk(cmd_code === 0 && rd_addr === 0, "R1 fields after reset",
        32'(rd_addr), 0);

    // R3/R5: normal dual read entering continuous mode, sclk idle low
    base = rd_count;
    push_opc(8'hBB); push_dual(24'h123456, 24); push_dual(24'h20, 8); push_fill(6);
    run_frame(0, 999);
    chk(rd_count == base + 1, "R3 one request", rd_count - base, 1);
    chk(last_addr == 24'h123456, "R3 address", last_addr, 24'h123456);
    chk(xip_active === 1, "R5 mode 10 enters", 32'(xip_active), 1);

    // R6/R9/R5: continuous frame, sclk idle high, ignored bits set
    base = rd_count;
    push_dual(24'hABCDEF, 24); push_dual(24'hEF, 8); push_fill(4);
    run_frame(1, 999);
    chk(rd_count == base + 1, "R6 opcode-less request", rd_count - base, 1);
    chk(last_addr == 24'hABCDEF, "R6 R9 address", last_addr, 24'hABCDEF);
    chk(cmd_code === 8'hBB, "R6 implied opcode", 32'(cmd_code), 32'hBB);
    chk(xip_active === 1, "R5 ignored bits keep mode", 32'(xip_active), 1);

    // R8: partial continuous frame aborted by deselect
    base = rd_count;
    push_dual(24'h000FFF, 24); push_dual(24'h00, 8);
    run_frame(0, 5);
    chk(rd_count == base, "R8 no request on abort", rd_count - base, 0);
    chk(xip_active === 1, "R8 state kept", 32'(xip_active), 1);

    // R5: continuous frame with mode 00 leaves
    base = rd_count;
    push_dual(24'h00A5A5, 24); push_dual(24'h00, 8);
    run_frame(0, 999);
    chk(last_addr == 24'h00A5A5, "R8 fresh frame address", last_addr, 24'h00A5A5);
    chk(xip_active === 0, "R5 mode 00 leaves", 32'(xip_active), 0);

    // R4: ordinary opcode
    base = rd_count;
    push_opc(8'h03); push_fill(30);
    run_frame(0, 999);
    chk(rd_count == base, "R4 no request", rd_count - base, 0);
    chk(cmd_code === 8'h03, "R4 R2 opcode", 32'(cmd_code), 32'h03);
    chk(xip_active === 0, "R4 state unchanged", 32'(xip_active), 0);

    // R5/R9: mode 01 and 11 in mode 3 do not enter
    push_opc(8'hBB); push_dual(24'hFEDCBA, 24); push_dual(24'hDF, 8);
    run_frame(1, 999);
    chk(xip_active === 0, "R5 mode 01 stays out", 32'(xip_active), 0);
    chk(last_addr == 24'hFEDCBA, "R9 mode3 address", last_addr, 24'hFEDCBA);
    push_opc(8'hBB); push_dual(24'h010203, 24); push_dual(24'h30, 8);
    run_frame(0, 999);
    chk(xip_active === 0, "R5 mode 11 stays out", 32'(xip_active), 0);

    // R7: enter, then all-ones break in continuous mode
    push_opc(8'hBB); push_dual(24'h111111, 24); push_dual(24'h2A, 8);
    run_frame(0, 999);
    chk(xip_active === 1, "R7 setup entered", 32'(xip_active), 1);
    base = rd_count;
    push_ones(16);
    run_frame(1, 999);
    chk(xip_active === 0, "R7 break leaves", 32'(xip_active), 0);
    chk(rd_count == base, "R7 break no request", rd_count - base, 0);
    push_opc(8'h9F); push_fill(8);
    run_frame(0, 999);
    chk(cmd_code === 8'h9F, "R7 normal decode after break", 32'(cmd_code), 32'h9F);

    // R7: break in normal mode
    push_ones(16);
    run_frame(0, 999);
    chk(xip_active === 0 && cmd_code === 8'hFF, "R7 break when idle",
        32'({xip_active, cmd_code}), 32'hFF);

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule